// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt requests from five sources (two external pins, two timer rollover strobes and a serial channel with separate receive and transmit completion strobes), holds them in request flags, and presents one winning request with its vector address to a CPU. Software configures it over a byte-wide register bus. There is one enable per source plus a global enable, a one-bit priority per source, and a sense type per external pin.

The CPU takes a request by pulsing `irq_ack` while `irq_req` is high. The controller then marks the winner's priority level as in service and clears the winner's flag if that source's rule says to. When the handler is done, the CPU pulses `irq_ret`, which releases the innermost active level. A low-level handler can be preempted only by a high-priority request. A high-level handler cannot be preempted.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, all four registers read 0 (flags at address 0, enables at address 1, priorities at address 2, pin sense types at address 3) and `irq_req` is low.
- R2: With a pin's sense bit at 0 (address 3, bit 0 for pin 0 and bit 1 for pin 1), a low pin sets that pin's flag (address 0, bit 0 for pin 0 and bit 2 for pin 1) on the third rising clock edge after the pin changes. An acknowledge does not clear the flag. While the pin stays low, the flag sets again even after software writes it to 0.
- R3: With a pin's sense bit at 1, only a high-to-low transition sets the flag. A rise, or a pin held low, sets nothing. Acknowledging that source clears its flag.
- R4: A one-cycle strobe on `tmr_ovf[0]` or `tmr_ovf[1]` sets flag bit 1 or bit 3 at that clock edge. Acknowledging that timer source clears its flag.
- R5: `ser_rx_done` sets flag bit 4 and `ser_tx_done` sets flag bit 5. Either flag raises the serial request. An acknowledge leaves both flags set, and only a software write of 0 clears them.
- R6: A write to address 0 replaces the flags with `reg_wdata[5:0]`. A hardware set in the same cycle wins over the write. A flag set by software produces the same request and vector as one set by hardware.
- R7: A source requests only when its enable bit and the global enable are both 1. The enable bits are address 1, bits 0 to 4 in poll order; the global enable is address 1, bit 7.
- R8: The priority bits are address 2, bits 0 to 4 in poll order, where 1 means high. Any eligible high-priority request wins over every low-priority one.
- R9: Within one priority level, the lowest source index wins. The indices in poll order are external 0 (0), timer 0 (1), external 1 (2), timer 1 (3) and serial (4). `irq_vec` = 0x03 + 8 × index.
- R10: After a low-priority acknowledge, only high-priority requests are presented. After a high-priority acknowledge, no request is presented, whatever the enables are.
- R11: `irq_ret` clears the high in-service level if it is set, and otherwise clears the low level.
- R12: `irq_ack` while `irq_req` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin | input | 2 | External request pins, asynchronous, idle high |
| tmr_ovf | input | 2 | One-cycle timer rollover strobes |
| ser_rx_done | input | 1 | One-cycle serial receive completion strobe |
| ser_tx_done | input | 1 | One-cycle serial transmit completion strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_req | output | 1 | A request is presented to the CPU |
| irq_vec | output | 8 | Vector address of the presented request (0 when none) |
| irq_ack | input | 1 | CPU takes the presented request |
| irq_ret | input | 1 | CPU returns from the current handler |

## Verification
Each result has a fixed due time:

- Timer and serial strobes, register writes and acknowledges take effect at the clock edge that samples them. `irq_req`, `irq_vec` and the read data follow that edge combinationally.
- A pin change reaches its flag only at the third edge, because the input passes two synchronizer stages and then one edge-history stage.

The bench drives every stimulus just after a falling edge and checks at the falling edge after the last edge that is due. It also checks the pin path one edge early, to see that the flag is still clear. Arbitration is swept over all 32 request patterns against all 32 priority patterns, and each result is compared with a winner the bench computes itself.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_SRC  = 5;
  localparam int NUM_FLAG = 6;
  localparam int NUM_EXT  = 2;
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int DATA_W   = 8;
  localparam int GLB_BIT  = 7;

  // flag bit positions
  localparam int FB_EXT0 = 0;
  localparam int FB_TMR0 = 1;
  localparam int FB_EXT1 = 2;
  localparam int FB_TMR1 = 3;
  localparam int FB_RX   = 4;
  localparam int FB_TX   = 5;

  // source indices (poll order)
  localparam int SI_EXT0 = 0;
  localparam int SI_TMR0 = 1;
  localparam int SI_EXT1 = 2;
  localparam int SI_TMR1 = 3;
  localparam int SI_SER  = 4;

  // in-service level bits
  localparam int LVL_LO = 0;
  localparam int LVL_HI = 1;

  typedef enum logic [1:0] {
    RSEL_FLAG  = 2'd0,
    RSEL_ENA   = 2'd1,
    RSEL_PRI   = 2'd2,
    RSEL_SENSE = 2'd3
  } rsel_e;
endpackage

// File: rtl/vic_pin_sense.sv
module vic_pin_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_mode,
  output logic hit
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q, prev_d;
  logic cur;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
    cur    = sync_q[SYNC_STAGES-1];
    prev_d = cur;
    hit    = edge_mode ? (prev_q & ~cur) : ~cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/vic_flag_bank.sv
module vic_flag_bank
  import vic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FLAG-1:0] hw_set,
  input  logic                sw_we,
  input  logic [NUM_FLAG-1:0] sw_val,
  input  logic [NUM_FLAG-1:0] ack_clr,
  output logic [NUM_FLAG-1:0] flags_q
);
  logic [NUM_FLAG-1:0] base, flags_d;

  always_comb begin
    base    = sw_we ? sw_val : flags_q;
    flags_d = (base & ~ack_clr) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
(
  input  logic [NUM_SRC-1:0] live,
  input  logic [NUM_SRC-1:0] pri,
  input  logic [1:0]         busy,
  output logic               grant,
  output logic [SRC_W-1:0]   idx,
  output logic               idx_hi
);
  logic [NUM_SRC-1:0] hi_set, lo_set;
  logic [SRC_W-1:0]   hi_idx, lo_idx;
  logic               hi_ok, lo_ok;

  always_comb begin
    hi_set = live & pri;
    lo_set = live & ~pri;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NUM_SRC-1; i >= 0; i--) begin
      if (hi_set[i]) hi_idx = SRC_W'(i);
      if (lo_set[i]) lo_idx = SRC_W'(i);
    end
    hi_ok  = !busy[LVL_HI];
    lo_ok  = !busy[LVL_HI] && !busy[LVL_LO];
    grant  = 1'b0;
    idx    = '0;
    idx_hi = 1'b0;
    if (hi_ok && (|hi_set)) begin
      grant  = 1'b1;
      idx    = hi_idx;
      idx_hi = 1'b1;
    end else if (lo_ok && (|lo_set)) begin
      grant  = 1'b1;
      idx    = lo_idx;
    end
  end
endmodule

// File: rtl/vic_level_track.sv
module vic_level_track
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_hi,
  input  logic       release_i,
  output logic [1:0] busy_q
);
  logic [1:0] busy_d;

  always_comb begin
    busy_d = busy_q;
    if (release_i) begin
      if (busy_q[LVL_HI]) busy_d[LVL_HI] = 1'b0;
      else                busy_d[LVL_LO] = 1'b0;
    end
    if (take) busy_d[take_hi] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_pin,
  input  logic [1:0]         tmr_ovf,
  input  logic               ser_rx_done,
  input  logic               ser_tx_done,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_req,
  output logic [DATA_W-1:0]  irq_vec,
  input  logic               irq_ack,
  input  logic               irq_ret
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  // configuration registers
  logic [NUM_SRC-1:0] ena_q, ena_d, pri_q, pri_d;
  logic               glb_q, glb_d;
  logic [NUM_EXT-1:0] sense_q, sense_d;
  logic               we_flag, we_ena, we_pri, we_sense;
  rsel_e              rsel;
  logic               wdata_unused;

  assign wdata_unused = reg_wdata[6];

  always_comb begin
    rsel     = rsel_e'(reg_addr);
    we_flag  = reg_we && (rsel == RSEL_FLAG);
    we_ena   = reg_we && (rsel == RSEL_ENA);
    we_pri   = reg_we && (rsel == RSEL_PRI);
    we_sense = reg_we && (rsel == RSEL_SENSE);
    ena_d    = we_ena   ? reg_wdata[NUM_SRC-1:0] : ena_q;
    glb_d    = we_ena   ? reg_wdata[GLB_BIT]     : glb_q;
    pri_d    = we_pri   ? reg_wdata[NUM_SRC-1:0] : pri_q;
    sense_d  = we_sense ? reg_wdata[NUM_EXT-1:0] : sense_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ena_q   <= '0;
      glb_q   <= 1'b0;
      pri_q   <= '0;
      sense_q <= '0;
    end else begin
      ena_q   <= ena_d;
      glb_q   <= glb_d;
      pri_q   <= pri_d;
      sense_q <= sense_d;
    end
  end

  // external pin sensing
  logic [NUM_EXT-1:0] ext_hit;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
    vic_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .pin       (ext_pin[g]),
      .edge_mode (sense_q[g]),
      .hit       (ext_hit[g])
    );
  end

  // flags, arbitration, in-service tracking
  logic [NUM_FLAG-1:0] hw_set, ack_clr, flags_q;
  logic [NUM_SRC-1:0]  pend, live;
  logic                grant, win_hi, take;
  logic [SRC_W-1:0]    win_idx;
  logic [1:0]          busy_q;

  always_comb begin
    hw_set          = '0;
    hw_set[FB_EXT0] = ext_hit[0];
    hw_set[FB_TMR0] = tmr_ovf[0];
    hw_set[FB_EXT1] = ext_hit[1];
    hw_set[FB_TMR1] = tmr_ovf[1];
    hw_set[FB_RX]   = ser_rx_done;
    hw_set[FB_TX]   = ser_tx_done;

    pend          = '0;
    pend[SI_EXT0] = flags_q[FB_EXT0];
    pend[SI_TMR0] = flags_q[FB_TMR0];
    pend[SI_EXT1] = flags_q[FB_EXT1];
    pend[SI_TMR1] = flags_q[FB_TMR1];
    pend[SI_SER]  = flags_q[FB_RX] | flags_q[FB_TX];
    live          = pend & ena_q & {NUM_SRC{glb_q}};

    take    = irq_ack && grant;
    ack_clr = '0;
    if (take) begin
      case (int'(win_idx))
        SI_EXT0: ack_clr[FB_EXT0] = sense_q[0];
        SI_TMR0: ack_clr[FB_TMR0] = 1'b1;
        SI_EXT1: ack_clr[FB_EXT1] = sense_q[1];
        SI_TMR1: ack_clr[FB_TMR1] = 1'b1;
        default: ack_clr = '0;
      endcase
    end
  end

  vic_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .hw_set  (hw_set),
    .sw_we   (we_flag),
    .sw_val  (reg_wdata[NUM_FLAG-1:0]),
    .ack_clr (ack_clr),
    .flags_q (flags_q)
  );

  vic_arbiter u_arb (
    .live   (live),
    .pri    (pri_q),
    .busy   (busy_q),
    .grant  (grant),
    .idx    (win_idx),
    .idx_hi (win_hi)
  );

  vic_level_track u_lvl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .take      (take),
    .take_hi   (win_hi),
    .release_i (irq_ret),
    .busy_q    (busy_q)
  );

  // outputs
  always_comb begin
    irq_req = grant;
    irq_vec = grant ? DATA_W'(VEC_BASE + VEC_STEP * int'(win_idx)) : '0;
    reg_rdata = '0;
    case (rsel)
      RSEL_FLAG:  reg_rdata[NUM_FLAG-1:0] = flags_q;
      RSEL_ENA: begin
        reg_rdata[NUM_SRC-1:0] = ena_q;
        reg_rdata[GLB_BIT]     = glb_q;
      end
      RSEL_PRI:   reg_rdata[NUM_SRC-1:0] = pri_q;
      RSEL_SENSE: reg_rdata[NUM_EXT-1:0] = sense_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
#(
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq_req,
  input logic [DATA_W-1:0]   irq_vec,
  input logic                irq_ack,
  input logic                irq_ret,
  input logic                reg_we,
  input logic [1:0]          reg_addr,
  input logic [1:0]          tmr_ovf,
  input logic [NUM_FLAG-1:0] flags,
  input logic                glb,
  input logic [1:0]          busy,
  input logic                win_hi
);
  localparam logic [DATA_W-1:0] VEC_TMR0 = DATA_W'(VEC_BASE + VEC_STEP);
  localparam logic [DATA_W-1:0] VEC_SER  = DATA_W'(VEC_BASE + 4 * VEC_STEP);

  logic flag_wr;
  assign flag_wr = reg_we && (reg_addr == 2'd0);

  AST_GRANT_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glb); // R7

  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (int'(irq_vec) >= VEC_BASE && int'(irq_vec) <= VEC_BASE + 4 * VEC_STEP
                 && ((int'(irq_vec) - VEC_BASE) % VEC_STEP) == 0)); // R9

  AST_HI_SERVICE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy[LVL_HI] |-> !irq_req); // R10

  AST_LO_SERVICE_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[LVL_LO] && irq_req) |-> win_hi); // R10

  AST_TMR_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == VEC_TMR0 && !tmr_ovf[0] && !flag_wr)
      |=> !flags[FB_TMR0]); // R4

  AST_SER_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == VEC_SER && !flag_wr)
      |=> ((flags[FB_TX:FB_RX] & $past(flags[FB_TX:FB_RX])) == $past(flags[FB_TX:FB_RX]))); // R5

  AST_RET_DROPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && busy[LVL_HI]) |=> !busy[LVL_HI]); // R11

  AST_ACK_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !irq_ret) |=> (busy == $past(busy))); // R12
endmodule

bind vic_ctrl vic_checker #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) i_vic_checker (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .irq_ack  (irq_ack),
  .irq_ret  (irq_ret),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .tmr_ovf  (tmr_ovf),
  .flags    (flags_q),
  .glb      (glb_q),
  .busy     (busy_q),
  .win_hi   (win_hi)
);

// File: tb/test_vic_ctrl.sv
`timescale 1ns/1ps
module test_vic_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ext_pin;
  logic [1:0] tmr_ovf;
  logic       ser_rx_done, ser_tx_done;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic       irq_ack, irq_ret;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vic_ctrl i_vic_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // write: drive after falling edge, return at the falling edge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  // 0 tmr0, 1 tmr1, 2 rx, 3 tx, 4 ack, 5 ret
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: tmr_ovf[0] = 1'b1;
      1: tmr_ovf[1] = 1'b1;
      2: ser_rx_done = 1'b1;
      3: ser_tx_done = 1'b1;
      4: irq_ack = 1'b1;
      default: irq_ret = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    tmr_ovf = '0; ser_rx_done = 1'b0; ser_tx_done = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [8:0] exp_pick(input logic [4:0] pend, input logic [4:0] pri,
                                          input logic [1:0] busy);
    logic [4:0] hi, lo;
    hi = pend & pri;
    lo = pend & ~pri;
    if (busy[1]) return 9'h000;
    for (int i = 0; i < 5; i++) if (hi[i]) return {1'b1, 8'(3 + 8 * i)};
    if (busy[0]) return 9'h000;
    for (int i = 0; i < 5; i++) if (lo[i]) return {1'b1, 8'(3 + 8 * i)};
    return 9'h000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; ext_pin = 2'b11; tmr_ovf = '0; ser_rx_done = 1'b0; ser_tx_done = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; irq_ack = 1'b0; irq_ret = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    edges(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      check("R1 register", {24'h0, r}, 32'h0);
    end
    check("R1 irq_req", {31'h0, irq_req}, 32'h0);

    // R6 R8 R9 sweep: software-set flags, every request and priority pattern
    wr(2'd1, 8'h9F);
    for (int pr = 0; pr < 32; pr++) begin
      for (int p = 0; p < 32; p++) begin
        wr(2'd2, 8'(pr));
        wr(2'd0, {3'b000, 5'(p)});
        check("R6 R8 R9 pick", {23'h0, irq_req, irq_vec},
              {23'h0, exp_pick(5'(p), 5'(pr), 2'b00)});
      end
    end
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);

    // R7 enables
    wr(2'd0, 8'h1F);
    wr(2'd1, 8'h1F);
    check("R7 global off", {31'h0, irq_req}, 32'h0);
    wr(2'd1, 8'h80);
    check("R7 no source enable", {31'h0, irq_req}, 32'h0);
    wr(2'd1, 8'h84);
    check("R7 only ext1", {23'h0, irq_req, irq_vec}, 32'h113);
    wr(2'd1, 8'h9F);
    check("R7 all enabled", {23'h0, irq_req, irq_vec}, 32'h103);
    wr(2'd0, 8'h00);

    // R4 timers, R10 blocking, R11 return
    pulse(0);
    rd(2'd0, r);
    check("R4 tmr0 flag set", {24'h0, r}, 32'h02);
    check("R4 tmr0 vector", {23'h0, irq_req, irq_vec}, 32'h10B);
    pulse(4);
    rd(2'd0, r);
    check("R4 tmr0 flag cleared by ack", {24'h0, r}, 32'h00);
    pulse(1);
    check("R10 low blocked in low service", {31'h0, irq_req}, 32'h0);
    wr(2'd2, 8'h08);
    check("R10 high preempts low", {23'h0, irq_req, irq_vec}, 32'h11B);
    pulse(4);
    rd(2'd0, r);
    check("R4 tmr1 flag cleared by ack", {24'h0, r}, 32'h00);
    wr(2'd2, 8'h09);
    wr(2'd0, 8'h01);
    check("R10 high service masks high", {31'h0, irq_req}, 32'h0);
    pulse(5);
    check("R11 ret drops high first", {23'h0, irq_req, irq_vec}, 32'h103);
    wr(2'd2, 8'h08);
    check("R11 low still in service", {31'h0, irq_req}, 32'h0);
    pulse(5);
    check("R11 ret drops low", {23'h0, irq_req, irq_vec}, 32'h103);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);

    // R12 ack with nothing pending
    pulse(4);
    wr(2'd0, 8'h02);
    check("R12 idle ack ignored", {23'h0, irq_req, irq_vec}, 32'h10B);
    wr(2'd0, 8'h00);

    // R5 serial
    wr(2'd1, 8'h90);
    pulse(3);
    rd(2'd0, r);
    check("R5 tx flag", {24'h0, r}, 32'h20);
    check("R5 serial vector", {23'h0, irq_req, irq_vec}, 32'h123);
    pulse(4);
    rd(2'd0, r);
    check("R5 ack keeps tx", {24'h0, r}, 32'h20);
    pulse(5);
    check("R5 request again after ret", {23'h0, irq_req, irq_vec}, 32'h123);
    wr(2'd0, 8'h00);
    rd(2'd0, r);
    check("R5 software clear", {24'h0, r}, 32'h00);
    check("R5 no request", {31'h0, irq_req}, 32'h0);
    pulse(2);
    rd(2'd0, r);
    check("R5 rx flag", {24'h0, r}, 32'h10);
    check("R5 rx vector", {23'h0, irq_req, irq_vec}, 32'h123);
    wr(2'd0, 8'h00);

    // R2 level sense on pin 0
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h81);
    @(negedge clk) ext_pin[0] = 1'b0;
    edges(2);
    rd(2'd0, r);
    check("R2 not yet after two edges", {24'h0, r}, 32'h00);
    edges(1);
    rd(2'd0, r);
    check("R2 level flag on third edge", {24'h0, r}, 32'h01);
    check("R2 vector", {23'h0, irq_req, irq_vec}, 32'h103);
    pulse(4);
    rd(2'd0, r);
    check("R2 ack leaves level flag", {24'h0, r}, 32'h01);
    pulse(5);
    wr(2'd0, 8'h00);
    rd(2'd0, r);
    check("R2 flag re-sets while low", {24'h0, r}, 32'h01);
    @(negedge clk) ext_pin[0] = 1'b1;
    edges(3);
    wr(2'd0, 8'h00);
    rd(2'd0, r);
    check("R2 clear after release", {24'h0, r}, 32'h00);
    check("R2 no request", {31'h0, irq_req}, 32'h0);

    // R3 edge sense on pin 1
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h84);
    @(negedge clk) ext_pin[1] = 1'b0;
    edges(3);
    rd(2'd0, r);
    check("R3 falling edge sets", {24'h0, r}, 32'h04);
    check("R3 vector", {23'h0, irq_req, irq_vec}, 32'h113);
    pulse(4);
    rd(2'd0, r);
    check("R3 ack clears edge flag", {24'h0, r}, 32'h00);
    pulse(5);
    edges(5);
    rd(2'd0, r);
    check("R3 held low sets nothing", {24'h0, r}, 32'h00);
    check("R3 no request", {31'h0, irq_req}, 32'h0);
    @(negedge clk) ext_pin[1] = 1'b1;
    edges(4);
    rd(2'd0, r);
    check("R3 rise sets nothing", {24'h0, r}, 32'h00);
    @(negedge clk) ext_pin[1] = 1'b0;
    edges(3);
    rd(2'd0, r);
    check("R3 second fall sets", {24'h0, r}, 32'h04);
    @(negedge clk) ext_pin[1] = 1'b1;
    wr(2'd0, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule